// File: doc/BRIEF.md
# Masked Address Breakpoint Comparator

This block is a single channel of a hardware breakpoint unit. It observes every CPU bus cycle: the address, whether the cycle is an instruction fetch or an operand access, its direction and its access size, all qualified by a valid strobe. When a valid cycle hits a programmed reference address and also satisfies the programmed cycle conditions, the block raises a break request for exactly one clock. The address comparison can leave out a selectable group of low bits, so one channel can cover a whole page or region.

Software programs the channel through a small register port that has three targets: a 32-bit reference address, an 8-bit control register whose mask code sits in bits 3, 1 and 0, and a 16-bit cycle-condition register. That register selects the access type, the direction and the size. A standby input freezes all programmed state.

The break request comes from a two-state machine. ST_IDLE is the reset state. The machine moves IDLE to FIRE (transition T_HIT) when the current valid bus cycle meets every condition. It stays in FIRE (T_AGAIN) when the next cycle also meets them. It returns to IDLE (T_DROP) on any cycle that does not. The request output is high only in ST_FIRE.

Top module: `brk_channel`

## Requirements
- R1: The 3-bit mask code is written from control bits {3,1,0}, with bit 3 as the most significant bit. Control readback returns the code in those same bits and 0 in bits 7:4 and 2.
- R2: Mask code 000 compares all 32 address bits. Code 001 ignores the low 10 bits, 010 ignores the low 12 bits, 100 ignores the low 16 bits and 101 ignores the low 20 bits.
- R3: Mask code 011 ignores the whole address, so any address matches.
- R4: A control write whose code is 110 or 111 leaves the stored code unchanged, and readback then returns the earlier code.
- R5: The cycle-condition register holds the size MSB in bit 6, the type select in bits 5:4, the direction select in bits 3:2 and the size LSBs in bits 1:0. Bits 15:7 read 0 and ignore writes. Register select 00 is the address, 01 is control, 10 is cycle-condition, and 11 reads 0.
- R6: After reset all three registers read 0, and the channel raises no break.
- R7: While `stby` is high, register writes have no effect.
- R8: Type select: 00 never matches, 01 matches instruction fetches (`bus_ifetch`=1), 10 matches operand accesses and 11 matches both.
- R9: Direction select: 00 never matches, 01 matches reads (`bus_write`=0), 10 matches writes and 11 matches both.
- R10: Size code {bit6,bit1,bit0} = 000 matches any size. Codes 001, 010, 011 and 100 match `bus_size` 00 (byte), 01 (word), 10 (longword) and 11 (quadword). Codes 101 to 111 never match.
- R11: `brk_req` is high for exactly the one clock that follows a valid bus cycle meeting every condition. It is low after any cycle in which `bus_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| stby | input | 1 | Standby: holds all registers |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register readback (combinational) |
| bus_valid | input | 1 | Bus cycle valid strobe |
| bus_addr | input | 32 | Bus cycle address |
| bus_ifetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code |
| brk_req | output | 1 | Registered break request |

## Verification
The bench builds the block with its default parameters: a 32-bit address and drop widths of 10, 12, 16 and 20 bits. With these values each mask code can be probed at its exact edge. For each code the bench flips the highest ignored bit, which must still match, and the lowest compared bit, which must not. The defaults also expose every size, type and direction encoding, so each condition can be tested on its own with the others left permissive.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [2:0] {
        MSK_FULL = 3'b000,
        MSK_LO_A = 3'b001,
        MSK_LO_B = 3'b010,
        MSK_NONE = 3'b011,
        MSK_LO_C = 3'b100,
        MSK_LO_D = 3'b101
    } mask_code_e;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'b00,
        SEL_CTRL = 2'b01,
        SEL_COND = 2'b10,
        SEL_NONE = 2'b11
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } brk_state_e;

    typedef struct packed {
        logic [2:0] size_code;
        logic [1:0] type_sel;
        logic [1:0] dir_sel;
    } cond_t;

endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [ADDR_W-1:0] ref_addr,
    output logic [2:0]        mask_code,
    output cond_t             cond
);

    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        code_q;
    cond_t             cond_q;
    logic [2:0]        code_in;
    logic              code_ok;
    logic              wr_en;

    assign wr_en   = reg_we && !stby;
    assign code_in = {reg_wdata[3], reg_wdata[1], reg_wdata[0]};
    assign code_ok = !(code_in[2] && code_in[1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            code_q <= MSK_FULL;
            cond_q <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_ADDR: addr_q <= reg_wdata[ADDR_W-1:0];
                SEL_CTRL: if (code_ok) code_q <= code_in;
                SEL_COND: begin
                    cond_q.size_code <= {reg_wdata[6], reg_wdata[1:0]};
                    cond_q.type_sel  <= reg_wdata[5:4];
                    cond_q.dir_sel   <= reg_wdata[3:2];
                end
                SEL_NONE: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_sel))
            SEL_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
            SEL_CTRL: reg_rdata[3:0] = {code_q[2], 1'b0, code_q[1:0]};
            SEL_COND: reg_rdata[6:0] = {cond_q.size_code[2], cond_q.type_sel,
                                        cond_q.dir_sel, cond_q.size_code[1:0]};
            SEL_NONE: reg_rdata = '0;
        endcase
    end

    assign ref_addr  = addr_q;
    assign mask_code = code_q;
    assign cond      = cond_q;

    a_r4_no_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_q[2] && code_q[1]));

    a_r7_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stby |=> ($stable(addr_q) && $stable(code_q) && $stable(cond_q)));

    a_r4_reserved_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_CTRL && reg_wdata[3] && reg_wdata[1]) |=> $stable(code_q));

endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DROP_A = 10,
    parameter int DROP_B = 12,
    parameter int DROP_C = 16,
    parameter int DROP_D = 20
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [2:0]        mask_code,
    output logic              addr_hit
);

    localparam int DROP_W = $clog2(ADDR_W + 1);

    logic [DROP_W-1:0] drop;
    logic [ADDR_W-1:0] bit_ok;

    always_comb begin
        drop = '0;
        unique case (mask_code)
            MSK_FULL: drop = '0;
            MSK_LO_A: drop = DROP_W'(DROP_A);
            MSK_LO_B: drop = DROP_W'(DROP_B);
            MSK_NONE: drop = DROP_W'(ADDR_W);
            MSK_LO_C: drop = DROP_W'(DROP_C);
            MSK_LO_D: drop = DROP_W'(DROP_D);
            default:  drop = '0;
        endcase
    end

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_ok[i] = (DROP_W'(i) < drop) || (bus_addr[i] == ref_addr[i]);
    end

    assign addr_hit = &bit_ok;

endmodule

// File: rtl/brk_cycle_qual.sv
module brk_cycle_qual
    import brk_pkg::*;
(
    input  cond_t      cond,
    input  logic       bus_ifetch,
    input  logic       bus_write,
    input  logic [1:0] bus_size,
    output logic       cycle_hit
);

    logic type_ok;
    logic dir_ok;
    logic size_ok;

    always_comb begin
        type_ok = bus_ifetch ? cond.type_sel[0] : cond.type_sel[1];
        dir_ok  = bus_write  ? cond.dir_sel[1]  : cond.dir_sel[0];
        unique case (cond.size_code)
            3'b000:  size_ok = 1'b1;
            3'b001:  size_ok = (bus_size == 2'b00);
            3'b010:  size_ok = (bus_size == 2'b01);
            3'b011:  size_ok = (bus_size == 2'b10);
            3'b100:  size_ok = (bus_size == 2'b11);
            default: size_ok = 1'b0;
        endcase
    end

    assign cycle_hit = type_ok && dir_ok && size_ok;

endmodule

// File: rtl/brk_channel.sv
module brk_channel
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DROP_A = 10,
    parameter int DROP_B = 12,
    parameter int DROP_C = 16,
    parameter int DROP_D = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ifetch,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    output logic              brk_req
);

    logic [ADDR_W-1:0] ref_addr;
    logic [2:0]        mask_code;
    cond_t             cond;
    logic              addr_hit;
    logic              cycle_hit;
    logic              hit;
    brk_state_e        state_q;
    brk_state_e        state_d;

    brk_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .stby      (stby),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ref_addr  (ref_addr),
        .mask_code (mask_code),
        .cond      (cond)
    );

    brk_addr_cmp #(
        .ADDR_W (ADDR_W),
        .DROP_A (DROP_A),
        .DROP_B (DROP_B),
        .DROP_C (DROP_C),
        .DROP_D (DROP_D)
    ) u_addr (
        .bus_addr  (bus_addr),
        .ref_addr  (ref_addr),
        .mask_code (mask_code),
        .addr_hit  (addr_hit)
    );

    brk_cycle_qual u_qual (
        .cond       (cond),
        .bus_ifetch (bus_ifetch),
        .bus_write  (bus_write),
        .bus_size   (bus_size),
        .cycle_hit  (cycle_hit)
    );

    assign hit = bus_valid && addr_hit && cycle_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_HIT, T_AGAIN, T_DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = hit ? ST_FIRE : ST_IDLE;
            ST_FIRE: state_d = hit ? ST_FIRE : ST_IDLE;
        endcase
    end

    // output
    always_comb begin
        brk_req = (state_q == ST_FIRE);
    end

    a_r11_req_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(bus_valid));

    a_r11_req_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(addr_hit && cycle_hit));

    a_r11_hit_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> brk_req);

    a_r5_cond_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_COND) |-> (reg_rdata[31:7] == '0));

endmodule

// File: tb/brk_channel_tb.sv
`timescale 1ns/1ps
module brk_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stby = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'b00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_ifetch = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'b00;
    logic        brk_req;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    brk_channel u_dut (
        .clk(clk), .rst_n(rst_n), .stby(stby), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_ifetch(bus_ifetch),
        .bus_write(bus_write), .bus_size(bus_size), .brk_req(brk_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    // one bus cycle; returns brk_req in the following clock
    task automatic cyc(input logic [31:0] a, input logic ifx, input logic w,
                       input logic [1:0] sz, input logic v, output logic req);
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_ifetch = ifx; bus_write = w; bus_size = sz;
        @(posedge clk);
        #1 req = brk_req;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    localparam logic [31:0] REF = 32'hA5C3_7E19;
    localparam logic [31:0] COND_ANY = 32'h0000_003C; // type 11, dir 11, size 000

    task automatic t_reset;
        logic [31:0] d; logic r;
        rd(2'b00, d); check("R6 addr reset", d, 0);
        rd(2'b01, d); check("R6 ctrl reset", d, 0);
        rd(2'b10, d); check("R6 cond reset", d, 0);
        cyc(32'h0, 1'b1, 1'b0, 2'b00, 1'b1, r); check("R6 no break after reset", r, 0);
    endtask

    task automatic t_mask_edges;
        logic r;
        int drops[5] = '{0, 10, 12, 16, 20};
        logic [31:0] codes[5] = '{32'h0, 32'h1, 32'h2, 32'h8, 32'h9};
        wr(2'b00, REF);
        wr(2'b10, COND_ANY);
        for (int k = 0; k < 5; k++) begin
            wr(2'b01, codes[k]);
            cyc(REF, 1'b0, 1'b0, 2'b10, 1'b1, r); check("R2 exact hit", r, 1);
            if (drops[k] > 0) begin
                cyc(REF ^ (32'h1 << (drops[k]-1)), 1'b0, 1'b0, 2'b10, 1'b1, r);
                check("R2 top ignored bit", r, 1);
            end
            cyc(REF ^ (32'h1 << drops[k]), 1'b0, 1'b0, 2'b10, 1'b1, r);
            check("R2 lowest compared bit", r, 0);
            cyc(REF ^ 32'h8000_0000, 1'b0, 1'b0, 2'b10, 1'b1, r);
            check("R2 msb compared", r, 0);
        end
    endtask

    task automatic t_mask_all;
        logic r; logic [31:0] d;
        wr(2'b01, 32'h3);
        rd(2'b01, d); check("R1 readback code 011", d, 32'h3);
        cyc(~REF, 1'b1, 1'b1, 2'b11, 1'b1, r); check("R3 any address", r, 1);
        cyc(32'h0, 1'b0, 1'b0, 2'b00, 1'b1, r); check("R3 zero address", r, 1);
    endtask

    task automatic t_ctrl_layout;
        logic [31:0] d;
        wr(2'b01, 32'hFFFF_FFF5); // bits3=0? 0x5 -> bit3=0,bit1=0,bit0=1 -> code 001
        rd(2'b01, d); check("R1 code from bits 3,1,0", d, 32'h1);
        wr(2'b01, 32'h0000_0008); // code 100
        rd(2'b01, d); check("R1 bit3 is msb", d, 32'h8);
    endtask

    task automatic t_reserved;
        logic [31:0] d; logic r;
        wr(2'b01, 32'h9); // code 101
        wr(2'b01, 32'hA); // code 110 reserved
        rd(2'b01, d); check("R4 code 110 rejected", d, 32'h9);
        wr(2'b01, 32'hB); // code 111 reserved
        rd(2'b01, d); check("R4 code 111 rejected", d, 32'h9);
        cyc(REF ^ 32'h000F_FFFF, 1'b0, 1'b0, 2'b00, 1'b1, r);
        check("R4 old mask still active", r, 1);
    endtask

    task automatic t_cond_layout;
        logic [31:0] d;
        wr(2'b10, 32'hFFFF_FFFF);
        rd(2'b10, d); check("R5 upper bits read zero", d, 32'h7F);
        wr(2'b10, 32'h0000_0051); // bit6, type 01, dir 00, size lo 01
        rd(2'b10, d); check("R5 field positions", d, 32'h51);
        rd(2'b11, d); check("R5 select 11 reads zero", d, 0);
        wr(2'b10, COND_ANY);
    endtask

    task automatic t_standby;
        logic [31:0] d;
        stby = 1'b1;
        wr(2'b00, 32'h1234_5678);
        wr(2'b01, 32'h0);
        wr(2'b10, 32'h0);
        stby = 1'b0;
        rd(2'b00, d); check("R7 addr held", d, REF);
        rd(2'b01, d); check("R7 ctrl held", d, 32'h9);
        rd(2'b10, d); check("R7 cond held", d, COND_ANY);
    endtask

    task automatic t_type_dir;
        logic r;
        wr(2'b01, 32'h3); // any address
        wr(2'b10, 32'h0000_000C); // type 00
        cyc(REF, 1'b1, 1'b0, 2'b00, 1'b1, r); check("R8 type 00 disabled", r, 0);
        wr(2'b10, 32'h0000_001C); // type 01
        cyc(REF, 1'b1, 1'b0, 2'b00, 1'b1, r); check("R8 type 01 fetch", r, 1);
        cyc(REF, 1'b0, 1'b0, 2'b00, 1'b1, r); check("R8 type 01 operand", r, 0);
        wr(2'b10, 32'h0000_002C); // type 10
        cyc(REF, 1'b1, 1'b0, 2'b00, 1'b1, r); check("R8 type 10 fetch", r, 0);
        cyc(REF, 1'b0, 1'b0, 2'b00, 1'b1, r); check("R8 type 10 operand", r, 1);
        wr(2'b10, 32'h0000_0030); // dir 00
        cyc(REF, 1'b0, 1'b0, 2'b00, 1'b1, r); check("R9 dir 00 disabled", r, 0);
        wr(2'b10, 32'h0000_0034); // dir 01
        cyc(REF, 1'b0, 1'b0, 2'b00, 1'b1, r); check("R9 dir 01 read", r, 1);
        cyc(REF, 1'b0, 1'b1, 2'b00, 1'b1, r); check("R9 dir 01 write", r, 0);
        wr(2'b10, 32'h0000_0038); // dir 10
        cyc(REF, 1'b0, 1'b0, 2'b00, 1'b1, r); check("R9 dir 10 read", r, 0);
        cyc(REF, 1'b0, 1'b1, 2'b00, 1'b1, r); check("R9 dir 10 write", r, 1);
    endtask

    task automatic t_size;
        logic r; logic [31:0] w; logic [2:0] c;
        for (int code = 0; code < 8; code++) begin
            c = 3'(code);
            w = {25'h0, c[2], 6'b1111_00} | {30'h0, c[1:0]};
            wr(2'b10, w);
            for (int s = 0; s < 4; s++) begin
                cyc(REF, 1'b0, 1'b1, 2'(s), 1'b1, r);
                check("R10 size code", {31'h0, r},
                      {31'h0, (code == 0) || (code >= 1 && code <= 4 && s == code - 1)});
            end
        end
        wr(2'b10, COND_ANY);
    endtask

    task automatic t_pulse;
        logic r;
        cyc(REF, 1'b0, 1'b0, 2'b00, 1'b0, r); check("R11 valid low no break", r, 0);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = REF;
        @(posedge clk); #1 check("R11 high after hit", {31'h0, brk_req}, 1);
        @(negedge clk); bus_valid = 1'b0;
        @(posedge clk); #1 check("R11 one clock only", {31'h0, brk_req}, 0);
    endtask

    initial begin : watchdog
        #500000;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_layout();
        t_mask_edges();
        t_mask_all();
        t_reserved();
        t_cond_layout();
        wr(2'b01, 32'h9);
        t_standby();
        t_type_dir();
        t_size();
        t_pulse();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule